// File: doc/BRIEF.md
# PAL Composite Sync Timing Generator

This block produces the raster timing for a 15.625 kHz PAL-style display from a 16 MHz pixel clock. A free-running pixel counter and a line counter step through each 64 µs line. From them the block drives active-low horizontal, vertical and composite sync, plus an active-video enable. Every output is registered, and the outputs change in the same cycle as the counter values shown on the position ports.

Composite sync is assembled one line at a time from a five-bit pulse code. The code chooses an ordinary line sync, or a short equalising pulse or a long broad pulse in either half of the line. The code for the coming line is looked up from its line index and latched at the end of the line before it.

A mode input selects between two frame types. One is the standard 625-line interlaced frame, which has a half-line offset between its two fields. The other is a 312-line progressive frame that repeats one field with identical timing, so both fields overlay each other. The mode is sampled only at a frame boundary.

Top module: `pal_sync_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `h_pos` and `v_pos` become 0 and the outputs show the start of line 1: `hsync_n`=0, `csync_n`=0, `vsync_n`=0 and `de`=0.
- R2: `h_pos` counts from 0 to H_TOTAL-1 and then wraps to 0. `v_pos` (the line number minus one) advances only at that wrap. An interlaced frame ends after `v_pos`=624.
- R3: On every line, `hsync_n` is low exactly for `h_pos` < H_SYNC.
- R4: On an ordinary line (code 10000), `csync_n` is low only for `h_pos` < H_SYNC.
- R5: A short pulse keeps `csync_n` low for SHORT_W clocks. In the first half-line it starts at `h_pos`=0, and in the second half-line it starts at H_TOTAL/2.
- R6: A broad pulse keeps `csync_n` low for H_TOTAL/2-H_SYNC clocks. It starts at `h_pos`=0 in the first half-line and at H_TOTAL/2 in the second half-line.
- R7: The code bits are ordered {normal, short first half, short second half, broad first half, broad second half}. In both modes the codes are:
  - lines 1 and 2: 00011
  - line 3: 00110
  - lines 4, 5, 311 and 312: 01100
  - every other line not covered by R8: 10000
- R8: In interlaced mode (`prog_mode`=0), line 313 uses 01001 and lines 314 and 315 use 00011.
- R9: In progressive mode (`prog_mode`=1) a frame is 312 lines. After two short-pulse lines (311 and 312), the count wraps straight into the broad-pulse line 1, so there is no half-line offset.
- R10: `vsync_n` is low for the whole of every line whose code contains a broad pulse.
- R11: `de` is high only when `h_pos` lies in [H_SYNC+H_BACK, H_TOTAL-H_FRONT) on a line that is active and has code 10000. The active lines are:
  - progressive mode: lines 23 to 309
  - interlaced mode: lines 23 to 310 and lines 336 to 623
- R12: A change of `prog_mode` takes effect only when a frame wraps to line 1. The frame in progress keeps its own length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock (16 MHz with default parameters) |
| rst | input | 1 | Synchronous reset, active high |
| prog_mode | input | 1 | 1 = 312-line progressive, 0 = 625-line interlaced |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| csync_n | output | 1 | Composite sync, active low |
| de | output | 1 | Active-video enable |
| h_pos | output | $clog2(H_TOTAL) | Pixel position within the line |
| v_pos | output | 10 | Line index, equal to the line number minus one |

## Verification
The bench builds the block with a 64-clock line:
- H_SYNC=5, H_BACK=6, H_FRONT=2 and SHORT_W=3.
- The half-line is 32 clocks and the broad pulse is 27 clocks.

Because the pulse-code line numbers are fixed by the raster, the short line lets the bench run two full progressive frames and a full interlaced frame well inside its cycle budget. Over that run it samples the pulse edges of:
- the broad, short and mixed lines;
- the dropped line 310;
- both interlaced active windows.

The mode is switched in the middle of a frame to show that the change waits for the frame wrap.

// File: rtl/pal_sync_pkg.sv
package pal_sync_pkg;

  // Line counter width covers the 625-line interlaced frame.
  localparam int unsigned LINE_W       = 10;
  localparam int unsigned LINES_INTL   = 625;
  localparam int unsigned LINES_PROG   = 312;

  typedef logic [LINE_W-1:0] line_idx_t;

  // Per-line pulse code, MSB first: normal, short h1, short h2, broad h1, broad h2.
  typedef struct packed {
    logic normal;
    logic short1;
    logic short2;
    logic broad1;
    logic broad2;
  } pulse_code_t;

  localparam pulse_code_t CODE_NORMAL      = 5'b10000;
  localparam pulse_code_t CODE_BROAD_BROAD = 5'b00011;
  localparam pulse_code_t CODE_BROAD_SHORT = 5'b00110;
  localparam pulse_code_t CODE_SHORT_SHORT = 5'b01100;
  localparam pulse_code_t CODE_SHORT_BROAD = 5'b01001;

endpackage

// File: rtl/pal_line_counter.sv
module pal_line_counter
  import pal_sync_pkg::*;
#(
  parameter int unsigned H_TOTAL = 1024,
  localparam int unsigned HW = $clog2(H_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          prog_mode,
  output logic [HW-1:0] h_q,
  output line_idx_t     v_q,
  output logic [HW-1:0] h_nxt,
  output line_idx_t     v_nxt,
  output logic          mode_nxt,
  output logic          line_end
);

  localparam logic [HW-1:0] H_LAST    = HW'(H_TOTAL - 1);
  localparam line_idx_t     LAST_INTL = line_idx_t'(LINES_INTL - 1);
  localparam line_idx_t     LAST_PROG = line_idx_t'(LINES_PROG - 1);

  logic      mode_q;
  line_idx_t v_last;
  logic      frame_end;

  assign line_end  = (h_q == H_LAST);
  assign v_last    = mode_q ? LAST_PROG : LAST_INTL;
  assign frame_end = line_end && (v_q == v_last);

  always_comb begin
    h_nxt    = h_q + 1'b1;
    v_nxt    = v_q;
    mode_nxt = mode_q;
    if (line_end) begin
      h_nxt = '0;
      v_nxt = frame_end ? '0 : v_q + 1'b1;
    end
    // Mode is only sampled when a new frame begins.
    if (frame_end) begin
      mode_nxt = prog_mode;
    end
    if (rst) begin
      h_nxt    = '0;
      v_nxt    = '0;
      mode_nxt = prog_mode;
    end
  end

  always_ff @(posedge clk) begin
    h_q    <= h_nxt;
    v_q    <= v_nxt;
    mode_q <= mode_nxt;
  end

endmodule

// File: rtl/pal_line_code.sv
module pal_line_code
  import pal_sync_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        line_end,
  input  line_idx_t   v_nxt,
  input  logic        mode_nxt,
  output pulse_code_t code_nxt
);

  pulse_code_t lut;
  pulse_code_t code_q;

  // Index is line number minus one.
  always_comb begin
    unique case (v_nxt)
      line_idx_t'(0),   line_idx_t'(1):   lut = CODE_BROAD_BROAD;
      line_idx_t'(2):                     lut = CODE_BROAD_SHORT;
      line_idx_t'(3),   line_idx_t'(4),
      line_idx_t'(310), line_idx_t'(311): lut = CODE_SHORT_SHORT;
      line_idx_t'(312): lut = mode_nxt ? CODE_SHORT_SHORT : CODE_SHORT_BROAD;
      line_idx_t'(313), line_idx_t'(314): lut = mode_nxt ? CODE_NORMAL : CODE_BROAD_BROAD;
      default:                            lut = CODE_NORMAL;
    endcase
  end

  // Code for the next line is latched at the end of the current one.
  assign code_nxt = (rst || line_end) ? lut : code_q;

  always_ff @(posedge clk) begin
    code_q <= code_nxt;
  end

endmodule

// File: rtl/pal_pulse_shaper.sv
module pal_pulse_shaper
  import pal_sync_pkg::*;
#(
  parameter int unsigned H_TOTAL = 1024,
  parameter int unsigned H_SYNC  = 75,
  parameter int unsigned SHORT_W = 38,
  localparam int unsigned HW      = $clog2(H_TOTAL),
  localparam int unsigned HALF    = H_TOTAL / 2,
  localparam int unsigned BROAD_W = HALF - H_SYNC
) (
  input  logic [HW-1:0] h,
  input  pulse_code_t   code,
  output logic          hsync_low,
  output logic          vsync_low,
  output logic          csync_low
);

  localparam logic [HW-1:0] SYNC_END = HW'(H_SYNC);

  logic [1:0] short_bits;
  logic [1:0] broad_bits;
  logic [1:0] half_low;

  assign short_bits = {code.short2, code.short1};
  assign broad_bits = {code.broad2, code.broad1};

  for (genvar g = 0; g < 2; g++) begin : g_half
    localparam logic [HW-1:0] START     = HW'(g * HALF);
    localparam logic [HW-1:0] SHORT_END = HW'(g * HALF + SHORT_W);
    localparam logic [HW-1:0] BROAD_END = HW'(g * HALF + BROAD_W);
    logic in_short;
    logic in_broad;
    assign in_short    = (h >= START) && (h < SHORT_END);
    assign in_broad    = (h >= START) && (h < BROAD_END);
    assign half_low[g] = (short_bits[g] && in_short) || (broad_bits[g] && in_broad);
  end

  assign hsync_low = (h < SYNC_END);
  assign vsync_low = code.broad1 || code.broad2;
  assign csync_low = (code.normal && hsync_low) || (|half_low);

endmodule

// File: rtl/pal_active_window.sv
module pal_active_window
  import pal_sync_pkg::*;
#(
  parameter int unsigned H_TOTAL     = 1024,
  parameter int unsigned H_SYNC      = 75,
  parameter int unsigned H_BACK      = 91,
  parameter int unsigned H_FRONT     = 26,
  parameter int unsigned P_FIRST     = 22,
  parameter int unsigned P_LAST      = 308,
  parameter int unsigned I_FIRST     = 22,
  parameter int unsigned I_LAST      = 309,
  parameter int unsigned I_F2_OFFSET = 313,
  localparam int unsigned HW = $clog2(H_TOTAL)
) (
  input  logic [HW-1:0] h,
  input  line_idx_t     v,
  input  logic          prog,
  input  pulse_code_t   code,
  output logic          active
);

  localparam logic [HW-1:0] H_ACT_S = HW'(H_SYNC + H_BACK);
  localparam logic [HW-1:0] H_ACT_E = HW'(H_TOTAL - H_FRONT);
  localparam line_idx_t     PF      = line_idx_t'(P_FIRST);
  localparam line_idx_t     PL      = line_idx_t'(P_LAST);
  localparam line_idx_t     IF1     = line_idx_t'(I_FIRST);
  localparam line_idx_t     IL1     = line_idx_t'(I_LAST);
  localparam line_idx_t     IF2     = line_idx_t'(I_FIRST + I_F2_OFFSET);
  localparam line_idx_t     IL2     = line_idx_t'(I_LAST + I_F2_OFFSET);

  logic h_ok;
  logic v_ok;

  assign h_ok = (h >= H_ACT_S) && (h < H_ACT_E);

  always_comb begin
    if (prog) v_ok = (v >= PF) && (v <= PL);
    else      v_ok = ((v >= IF1) && (v <= IL1)) || ((v >= IF2) && (v <= IL2));
  end

  assign active = h_ok && v_ok && (code == CODE_NORMAL);

endmodule

// File: rtl/pal_sync_gen.sv
module pal_sync_gen
  import pal_sync_pkg::*;
#(
  parameter int unsigned H_TOTAL = 1024,
  parameter int unsigned H_SYNC  = 75,
  parameter int unsigned H_BACK  = 91,
  parameter int unsigned H_FRONT = 26,
  parameter int unsigned SHORT_W = 38,
  localparam int unsigned HW = $clog2(H_TOTAL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_mode,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              csync_n,
  output logic              de,
  output logic [HW-1:0]     h_pos,
  output logic [LINE_W-1:0] v_pos
);

  logic [HW-1:0] h_q;
  logic [HW-1:0] h_nxt;
  line_idx_t     v_q;
  line_idx_t     v_nxt;
  logic          mode_nxt;
  logic          line_end;
  pulse_code_t   code_nxt;
  logic          hs_low;
  logic          vs_low;
  logic          cs_low;
  logic          act;

  pal_line_counter #(.H_TOTAL(H_TOTAL)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .prog_mode(prog_mode),
    .h_q      (h_q),
    .v_q      (v_q),
    .h_nxt    (h_nxt),
    .v_nxt    (v_nxt),
    .mode_nxt (mode_nxt),
    .line_end (line_end)
  );

  pal_line_code u_code (
    .clk     (clk),
    .rst     (rst),
    .line_end(line_end),
    .v_nxt   (v_nxt),
    .mode_nxt(mode_nxt),
    .code_nxt(code_nxt)
  );

  pal_pulse_shaper #(
    .H_TOTAL(H_TOTAL),
    .H_SYNC (H_SYNC),
    .SHORT_W(SHORT_W)
  ) u_shape (
    .h        (h_nxt),
    .code     (code_nxt),
    .hsync_low(hs_low),
    .vsync_low(vs_low),
    .csync_low(cs_low)
  );

  pal_active_window #(
    .H_TOTAL(H_TOTAL),
    .H_SYNC (H_SYNC),
    .H_BACK (H_BACK),
    .H_FRONT(H_FRONT)
  ) u_act (
    .h     (h_nxt),
    .v     (v_nxt),
    .prog  (mode_nxt),
    .code  (code_nxt),
    .active(act)
  );

  // Outputs registered from next-state values so they line up with the counters.
  always_ff @(posedge clk) begin
    hsync_n <= ~hs_low;
    vsync_n <= ~vs_low;
    csync_n <= ~cs_low;
    de      <= act;
  end

  assign h_pos = h_q;
  assign v_pos = v_q;

endmodule

// File: rtl/pal_sync_chk.sv
module pal_sync_chk #(
  parameter int unsigned H_TOTAL = 1024,
  parameter int unsigned H_SYNC  = 75,
  parameter int unsigned H_BACK  = 91,
  parameter int unsigned H_FRONT = 26,
  localparam int unsigned HW = $clog2(H_TOTAL)
) (
  input logic          clk,
  input logic          rst,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic          csync_n,
  input logic          de,
  input logic [HW-1:0] h_pos,
  input logic [9:0]    v_pos
);

  localparam logic [HW-1:0] H_LAST  = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] H_ACT_S = HW'(H_SYNC + H_BACK);
  localparam logic [HW-1:0] H_ACT_E = HW'(H_TOTAL - H_FRONT);
  localparam logic [HW-1:0] S_END   = HW'(H_SYNC);

  // R2
  h_step_chk: assert property (@(posedge clk) disable iff (rst)
    (h_pos != H_LAST) |=> (h_pos == HW'($past(h_pos) + 1'b1)));

  // R2
  h_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (h_pos == H_LAST) |=> (h_pos == '0));

  // R2
  v_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (h_pos != H_LAST) |=> $stable(v_pos));

  // R2
  v_range_chk: assert property (@(posedge clk) disable iff (rst)
    v_pos < 10'd625);

  // R3
  hsync_width_chk: assert property (@(posedge clk) disable iff (rst)
    (hsync_n == (h_pos >= S_END)));

  // R10
  vsync_line_chk: assert property (@(posedge clk) disable iff (rst)
    (h_pos != H_LAST) |=> $stable(vsync_n));

  // R10
  vsync_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (!vsync_n && h_pos == '0) |-> !csync_n);

  // R11
  de_window_chk: assert property (@(posedge clk) disable iff (rst)
    de |-> (h_pos >= H_ACT_S && h_pos < H_ACT_E && vsync_n && csync_n));

endmodule

bind pal_sync_gen pal_sync_chk #(
  .H_TOTAL(H_TOTAL),
  .H_SYNC (H_SYNC),
  .H_BACK (H_BACK),
  .H_FRONT(H_FRONT)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .hsync_n(hsync_n),
  .vsync_n(vsync_n),
  .csync_n(csync_n),
  .de     (de),
  .h_pos  (h_pos),
  .v_pos  (v_pos)
);

// File: tb/pal_sync_gen_tb.sv
module pal_sync_gen_tb;

  localparam int unsigned H_TOTAL = 64;
  localparam int unsigned HW      = $clog2(H_TOTAL);
  localparam int          NVEC    = 42;

  // {prog(1), line number(10), h(6), req(4), exp {cs,hs,vs,de}(4)}
  localparam logic [24:0] VEC [NVEC] = '{
    {1'b1, 10'd1,   6'd0,  4'd6,  4'b0000},  // R6 broad first half
    {1'b1, 10'd1,   6'd26, 4'd6,  4'b0100},
    {1'b1, 10'd1,   6'd27, 4'd6,  4'b1100},
    {1'b1, 10'd1,   6'd32, 4'd6,  4'b0100},  // R6 broad second half
    {1'b1, 10'd1,   6'd58, 4'd6,  4'b0100},
    {1'b1, 10'd1,   6'd59, 4'd6,  4'b1100},
    {1'b1, 10'd3,   6'd26, 4'd7,  4'b0100},  // R7 line 3 broad then short
    {1'b1, 10'd3,   6'd32, 4'd7,  4'b0100},
    {1'b1, 10'd3,   6'd35, 4'd7,  4'b1100},
    {1'b1, 10'd4,   6'd2,  4'd5,  4'b0010},  // R5 short pulses
    {1'b1, 10'd4,   6'd3,  4'd5,  4'b1010},
    {1'b1, 10'd4,   6'd34, 4'd5,  4'b0110},
    {1'b1, 10'd4,   6'd35, 4'd5,  4'b1110},
    {1'b1, 10'd5,   6'd4,  4'd3,  4'b1010},  // R3 hsync outlasts short pulse
    {1'b1, 10'd6,   6'd4,  4'd4,  4'b0010},  // R4 normal line
    {1'b1, 10'd6,   6'd5,  4'd4,  4'b1110},
    {1'b1, 10'd6,   6'd32, 4'd4,  4'b1110},
    {1'b1, 10'd22,  6'd30, 4'd11, 4'b1110},  // R11 before first active line
    {1'b1, 10'd23,  6'd10, 4'd11, 4'b1110},
    {1'b1, 10'd23,  6'd11, 4'd11, 4'b1111},
    {1'b1, 10'd23,  6'd61, 4'd11, 4'b1111},
    {1'b1, 10'd23,  6'd62, 4'd11, 4'b1110},
    {1'b1, 10'd309, 6'd40, 4'd11, 4'b1111},
    {1'b1, 10'd310, 6'd40, 4'd11, 4'b1110},  // R11 dropped line
    {1'b1, 10'd311, 6'd33, 4'd7,  4'b0110},  // R7 short pulses at field end
    {1'b1, 10'd312, 6'd1,  4'd7,  4'b0010},
    {1'b0, 10'd23,  6'd11, 4'd11, 4'b1111},  // R11 interlaced field 1
    {1'b0, 10'd310, 6'd11, 4'd11, 4'b1111},
    {1'b0, 10'd311, 6'd11, 4'd11, 4'b1110},
    {1'b0, 10'd313, 6'd0,  4'd8,  4'b0000},  // R8 short then broad
    {1'b0, 10'd313, 6'd3,  4'd8,  4'b1000},
    {1'b0, 10'd313, 6'd5,  4'd8,  4'b1100},
    {1'b0, 10'd313, 6'd32, 4'd8,  4'b0100},
    {1'b0, 10'd313, 6'd58, 4'd8,  4'b0100},
    {1'b0, 10'd313, 6'd59, 4'd8,  4'b1100},
    {1'b0, 10'd314, 6'd26, 4'd8,  4'b0100},
    {1'b0, 10'd315, 6'd59, 4'd8,  4'b1100},
    {1'b0, 10'd316, 6'd5,  4'd10, 4'b1110},  // R10 vsync released
    {1'b0, 10'd335, 6'd11, 4'd11, 4'b1110},  // R11 interlaced field 2
    {1'b0, 10'd336, 6'd11, 4'd11, 4'b1111},
    {1'b0, 10'd623, 6'd61, 4'd11, 4'b1111},
    {1'b0, 10'd624, 6'd11, 4'd11, 4'b1110}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          prog_mode = 1'b1;
  logic          hsync_n, vsync_n, csync_n, de;
  logic [HW-1:0] h_pos;
  logic [9:0]    v_pos;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  pal_sync_gen #(
    .H_TOTAL(H_TOTAL), .H_SYNC(5), .H_BACK(6), .H_FRONT(2), .SHORT_W(3)
  ) u_dut (
    .clk(clk), .rst(rst), .prog_mode(prog_mode),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .csync_n(csync_n), .de(de),
    .h_pos(h_pos), .v_pos(v_pos)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_pos(input int line_idx, input int h);
    do @(negedge clk); while (!(v_pos == 10'(line_idx) && h_pos == HW'(h)));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cycles, 190000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic prev_prog;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(h_pos == '0 && v_pos == '0, "R1", "counters", {v_pos, h_pos}, 0);
    check({csync_n, hsync_n, vsync_n, de} == 4'b0000, "R1", "outputs",
          {csync_n, hsync_n, vsync_n, de}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(h_pos == HW'(1), "R2", "first step", h_pos, 1);

    prev_prog = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      logic        vp;
      logic [9:0]  vl;
      logic [5:0]  vh;
      logic [3:0]  vr;
      logic [3:0]  ve;
      {vp, vl, vh, vr, ve} = VEC[i];
      if (prev_prog && !vp) begin
        // R9 progressive wrap after 312 lines into broad line 1
        wait_pos(311, H_TOTAL - 1);
        @(negedge clk);
        check(v_pos == '0 && h_pos == '0, "R9", "wrap line", v_pos, 0);
        check(!csync_n && !vsync_n, "R9", "broad after wrap",
              {csync_n, vsync_n}, 0);
        // R12 change mid-frame, old length must still apply
        wait_pos(100, 0);
        prog_mode = 1'b0;
        wait_pos(311, H_TOTAL - 1);
        @(negedge clk);
        check(v_pos == '0, "R12", "frame length kept", v_pos, 0);
      end
      prev_prog = vp;
      wait_pos(int'(vl) - 1, int'(vh));
      check({csync_n, hsync_n, vsync_n, de} == ve,
            $sformatf("R%0d", vr), $sformatf("line %0d h %0d", vl, vh),
            {csync_n, hsync_n, vsync_n, de}, ve);
    end

    // R2 interlaced frame is 625 lines
    wait_pos(624, H_TOTAL - 1);
    @(negedge clk);
    check(v_pos == '0, "R2", "interlaced wrap", v_pos, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule